// File: doc/BRIEF.md
# 8-bit CPU Effective Address Generator

This block works out the effective operand address for an 8-bit accumulator processor with a 16-bit address space. On a start pulse it captures a 4-bit addressing-mode code, a penalty-enable bit, the address of the opcode byte and the two index registers. It then fetches the operand bytes, and any pointer bytes the mode needs, one byte at a time over a request/acknowledge read port. When it has what it needs, it raises a one-cycle done pulse. At that point it presents the effective address, the program counter of the next instruction, the instruction length and a flag asking for one extra cycle.

The surrounding pipeline decodes the opcode into a mode code and decides whether the instruction is eligible for the page-crossing penalty. Reads and penalty-exempt stores use the same mode codes and differ only in that enable bit. The final data access and the arithmetic stay outside this block.

Top module: `ea_gen`

## Requirements
- R1: Mode codes are 0 implicit, 1 accumulator, 2 immediate, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 absolute, 7 absolute+X, 8 absolute+Y, 9 indirect, 10 indexed-indirect X, 11 indirect-indexed Y, 12 relative; 13 to 15 behave as implicit. `op_len` is 1 for codes 0, 1 and 13 to 15, 3 for codes 6 to 9 and 2 otherwise, and `pc_out` equals `pc_in + op_len` modulo 65536.
- R2: Implicit, accumulator, reserved and immediate modes issue no reads and pulse `done` in the cycle after start. Immediate returns `pc_in + 1` as the address and the others return 0.
- R3: Zero-page modes read one operand byte at `pc_in + 1`. The address is that byte, or that byte plus X or Y, truncated to 8 bits, so its upper byte is always 0.
- R4: Absolute modes read the low operand byte at `pc_in + 1` and the high byte at `pc_in + 2`. The indexed forms add X or Y to the 16-bit base modulo 65536.
- R5: Indirect mode reads a 16-bit pointer at the absolute operand address, low byte first. The high byte is read from the same 256-byte page, with its low address byte incremented modulo 256.
- R6: Indexed-indirect mode forms a pointer address as the operand byte plus X modulo 256 in page zero. It reads the low byte there and the high byte at the next page-zero location, wrapping 0xFF to 0x00. The result is that pointer.
- R7: Indirect-indexed mode reads a page-zero pointer at the operand byte, with the same wrap, and adds Y as a full 16-bit sum.
- R8: `extra_cyc` is 1 only when `pen_en` was 1 at start, the mode is 7, 8 or 11, and the upper byte of the base differs from the upper byte of base plus index. In all other cases it is 0.
- R9: Relative mode sign-extends the operand byte and adds it to `pc_in + 2` modulo 65536.
- R10: `mem_req` stays high with a stable `mem_addr` until a cycle in which `mem_ack` is high, and exactly one byte is taken per acknowledged cycle.
- R11: `done` is high for exactly one cycle, and the result outputs hold their values after it until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (accepted when idle) |
| mode | input | 4 | Addressing-mode code |
| pen_en | input | 1 | Enable page-crossing penalty for this instruction |
| pc_in | input | 16 | Address of the opcode byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_ack | input | 1 | Read data valid / request accepted |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address |
| pc_out | output | 16 | Program counter of the next instruction |
| op_len | output | 2 | Instruction length in bytes |
| extra_cyc | output | 1 | Page-crossing extra cycle request |

## Verification
Some properties are checked on every cycle. A pending request must hold its address until acknowledged. Done lasts a single cycle. A pointer high-byte fetch stays in the page of its low byte. The fast modes finish without touching the port. Zero-page results stay in page zero, and the extra-cycle flag never rises outside an enabled, indexable mode.

Only the directed scenarios can show that the arithmetic itself is right. These cover index wraps at 0xFF, crossings that do and do not set the flag, pointers straddling a page end, backward branches and wrap of the program counter, all under different memory latencies.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam logic [3:0] MD_IMP = 4'd0;
  localparam logic [3:0] MD_ACC = 4'd1;
  localparam logic [3:0] MD_IMM = 4'd2;
  localparam logic [3:0] MD_ZP  = 4'd3;
  localparam logic [3:0] MD_ZPX = 4'd4;
  localparam logic [3:0] MD_ZPY = 4'd5;
  localparam logic [3:0] MD_ABS = 4'd6;
  localparam logic [3:0] MD_ABX = 4'd7;
  localparam logic [3:0] MD_ABY = 4'd8;
  localparam logic [3:0] MD_IND = 4'd9;
  localparam logic [3:0] MD_IZX = 4'd10;
  localparam logic [3:0] MD_IZY = 4'd11;
  localparam logic [3:0] MD_REL = 4'd12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPLO, ST_OPHI, ST_PLO, ST_PHI, ST_DONE
  } ea_state_e;

  typedef struct packed {
    logic [1:0] len;    // instruction bytes
    logic       fetch;  // needs any memory read
    logic       two_op; // needs a second operand byte
    logic       ptr;    // needs a pointer fetch
    logic       ind;    // pointer address comes from absolute operand
    logic       izx;    // pointer address indexed by X
  } ea_ctl_t;
endpackage

// File: rtl/ea_len_dec.sv
module ea_len_dec
  import ea_pkg::*;
(
  input  logic [3:0] mode,
  output ea_ctl_t    ctl
);
  always_comb begin
    ctl = '0;
    ctl.len = 2'd1;
    case (mode)
      MD_IMM: ctl.len = 2'd2;
      MD_ZP, MD_ZPX, MD_ZPY, MD_REL: begin
        ctl.len   = 2'd2;
        ctl.fetch = 1'b1;
      end
      MD_ABS, MD_ABX, MD_ABY: begin
        ctl.len    = 2'd3;
        ctl.fetch  = 1'b1;
        ctl.two_op = 1'b1;
      end
      MD_IND: begin
        ctl.len    = 2'd3;
        ctl.fetch  = 1'b1;
        ctl.two_op = 1'b1;
        ctl.ptr    = 1'b1;
        ctl.ind    = 1'b1;
      end
      MD_IZX: begin
        ctl.len   = 2'd2;
        ctl.fetch = 1'b1;
        ctl.ptr   = 1'b1;
        ctl.izx   = 1'b1;
      end
      MD_IZY: begin
        ctl.len   = 2'd2;
        ctl.fetch = 1'b1;
        ctl.ptr   = 1'b1;
      end
      default: ctl.len = 2'd1;
    endcase
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [3:0]    mode,
  input  logic          pen,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] b0,
  input  logic [DW-1:0] b1,
  input  logic [DW-1:0] p0,
  input  logic [DW-1:0] p1,
  input  logic [1:0]    len,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] pc_nxt,
  output logic          extra
);
  localparam int HW = AW - DW;

  logic [DW-1:0] zp_sum;
  logic [AW-1:0] idx_base, idx_sum, rel_off;
  logic [DW-1:0] idx_val;
  logic          idx_mode;

  always_comb begin
    zp_sum   = b0 + ((mode == MD_ZPX) ? x : (mode == MD_ZPY) ? y : '0);
    idx_base = (mode == MD_IZY) ? AW'({p1, p0}) : AW'({b1, b0});
    idx_val  = (mode == MD_ABX) ? x : y;
    idx_sum  = idx_base + {{HW{1'b0}}, idx_val};
    idx_mode = (mode == MD_ABX) || (mode == MD_ABY) || (mode == MD_IZY);
    rel_off  = {{HW{b0[DW-1]}}, b0};
    extra    = pen && idx_mode && (idx_base[AW-1:DW] != idx_sum[AW-1:DW]);
    pc_nxt   = pc + {{(AW-2){1'b0}}, len};
    case (mode)
      MD_IMM:                 ea = pc + AW'(1);
      MD_ZP, MD_ZPX, MD_ZPY:  ea = {{HW{1'b0}}, zp_sum};
      MD_ABS:                 ea = AW'({b1, b0});
      MD_ABX, MD_ABY, MD_IZY: ea = idx_sum;
      MD_IND, MD_IZX:         ea = AW'({p1, p0});
      MD_REL:                 ea = pc + AW'(2) + rel_off;
      default:                ea = '0;
    endcase
  end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic          pen_en,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic          in_fetch,
  input  ea_ctl_t       ctl_q,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          done,
  output logic [3:0]    mode_q,
  output logic          pen_q,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output logic [DW-1:0] b0_q,
  output logic [DW-1:0] b1_q,
  output logic [DW-1:0] p0_q,
  output logic [DW-1:0] p1_q
);
  localparam int HW = AW - DW;

  ea_state_e     st_q, st_d;
  logic          ld_en, b0_en, b1_en, p0_en, p1_en;
  logic [AW-1:0] ptr_base;

  // pointer location for the low byte; high byte stays in its page
  always_comb begin
    if (ctl_q.ind) ptr_base = AW'({b1_q, b0_q});
    else           ptr_base = {{HW{1'b0}}, b0_q + (ctl_q.izx ? x_q : '0)};
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = in_fetch ? ST_OPLO : ST_DONE;
      ST_OPLO: if (mem_ack) st_d = ctl_q.two_op ? ST_OPHI :
                                   ctl_q.ptr    ? ST_PLO  : ST_DONE;
      ST_OPHI: if (mem_ack) st_d = ctl_q.ind ? ST_PLO : ST_DONE;
      ST_PLO:  if (mem_ack) st_d = ST_PHI;
      ST_PHI:  if (mem_ack) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ld_en = (st_q == ST_IDLE) && start;
    b0_en = (st_q == ST_OPLO) && mem_ack;
    b1_en = (st_q == ST_OPHI) && mem_ack;
    p0_en = (st_q == ST_PLO)  && mem_ack;
    p1_en = (st_q == ST_PHI)  && mem_ack;
    mem_req = (st_q == ST_OPLO) || (st_q == ST_OPHI) ||
              (st_q == ST_PLO)  || (st_q == ST_PHI);
    done = (st_q == ST_DONE);
    case (st_q)
      ST_OPLO: mem_addr = pc_q + AW'(1);
      ST_OPHI: mem_addr = pc_q + AW'(2);
      ST_PLO:  mem_addr = ptr_base;
      ST_PHI:  mem_addr = {ptr_base[AW-1:DW], ptr_base[DW-1:0] + DW'(1)};
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pen_q  <= 1'b0;
      pc_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
    end else if (ld_en) begin
      mode_q <= mode;
      pen_q  <= pen_en;
      pc_q   <= pc_in;
      x_q    <= idx_x;
      y_q    <= idx_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b0_q <= '0;
      b1_q <= '0;
      p0_q <= '0;
      p1_q <= '0;
    end else begin
      if (b0_en) b0_q <= mem_rdata;
      if (b1_en) b1_q <= mem_rdata;
      if (p0_en) p0_q <= mem_rdata;
      if (p1_en) p1_q <= mem_rdata;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R10
  AST_PTR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PLO && mem_ack) |=> (mem_addr[AW-1:DW] == $past(mem_addr[AW-1:DW]) &&
      mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) + DW'(1))); // R5
  AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && !in_fetch) |=> (done && !mem_req)); // R2
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic          pen_en,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] pc_out,
  output logic [1:0]    op_len,
  output logic          extra_cyc
);
  ea_ctl_t       ctl_in, ctl_q;
  logic [3:0]    mode_q;
  logic          pen_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] x_q, y_q, b0_q, b1_q, p0_q, p1_q;

  ea_len_dec u_dec_in (.mode(mode),   .ctl(ctl_in));
  ea_len_dec u_dec_q  (.mode(mode_q), .ctl(ctl_q));

  ea_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pen_en(pen_en),
    .pc_in(pc_in), .idx_x(idx_x), .idx_y(idx_y), .in_fetch(ctl_in.fetch),
    .ctl_q(ctl_q), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .done(done),
    .mode_q(mode_q), .pen_q(pen_q), .pc_q(pc_q), .x_q(x_q), .y_q(y_q),
    .b0_q(b0_q), .b1_q(b1_q), .p0_q(p0_q), .p1_q(p1_q)
  );

  ea_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode(mode_q), .pen(pen_q), .pc(pc_q), .x(x_q), .y(y_q),
    .b0(b0_q), .b1(b1_q), .p0(p0_q), .p1(p1_q), .len(ctl_q.len),
    .ea(ea), .pc_nxt(pc_out), .extra(extra_cyc)
  );

  assign op_len = ctl_q.len;

  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == MD_ZP || mode_q == MD_ZPX || mode_q == MD_ZPY))
      |-> (ea[AW-1:DW] == '0)); // R3
  AST_EXTRA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(pen_q && (mode_q == MD_ABX || mode_q == MD_ABY || mode_q == MD_IZY)))
      |-> !extra_cyc); // R8
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (op_len != 2'd0)); // R1
endmodule

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic        pen_en;
  logic [15:0] pc_in;
  logic [7:0]  idx_x, idx_y;
  logic        mem_req, mem_ack, done, extra_cyc;
  logic [15:0] mem_addr, ea, pc_out;
  logic [7:0]  mem_rdata;
  logic [1:0]  op_len;

  int n_chk = 0, n_bad = 0;
  int lat = 0, cnt = 0, reads = 0, hs_err = 0;
  logic        pend = 1'b0;
  logic [15:0] pend_addr = '0;
  logic [15:0] ov_a [16];
  logic [7:0]  ov_d [16];
  int ov_n = 0;

  always #2 clk = ~clk;

  ea_gen u0 (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pen_en(pen_en),
    .pc_in(pc_in), .idx_x(idx_x), .idx_y(idx_y), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .ea(ea), .pc_out(pc_out), .op_len(op_len), .extra_cyc(extra_cyc));

  function automatic logic [7:0] rd(input logic [15:0] a);
    for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) return ov_d[i];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    ov_a[ov_n] = a; ov_d[ov_n] = d; ov_n++;
  endtask

  // memory responder and handshake monitor (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && !(mem_req && mem_addr == pend_addr)) hs_err++;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (cnt >= lat) begin
          mem_ack = 1'b1; mem_rdata = rd(mem_addr); cnt = 0; reads++;
        end else cnt++;
      end
      pend = mem_req && !mem_ack;
      pend_addr = mem_addr;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_len(input logic [3:0] m);
    if (m <= 4'd1 || m >= 4'd13) return 2'd1;
    if (m >= 4'd6 && m <= 4'd9) return 2'd3;
    return 2'd2;
  endfunction

  function automatic logic [15:0] ref_ea(input logic [3:0] m, input logic [15:0] pc,
                                         input logic [7:0] x, input logic [7:0] y,
                                         output logic ref_cross);
    logic [7:0] b0, b1, t;
    logic [15:0] base, s;
    b0 = rd(pc + 16'd1); b1 = rd(pc + 16'd2);
    ref_cross = 1'b0;
    case (m)
      4'd2:  return pc + 16'd1;
      4'd3:  return {8'h00, b0};
      4'd4:  begin t = b0 + x; return {8'h00, t}; end
      4'd5:  begin t = b0 + y; return {8'h00, t}; end
      4'd6:  return {b1, b0};
      4'd7, 4'd8: begin
        base = {b1, b0}; s = base + {8'h00, (m == 4'd7) ? x : y};
        ref_cross = base[15:8] != s[15:8]; return s;
      end
      4'd9:  begin t = b0 + 8'd1; return {rd({b1, t}), rd({b1, b0})}; end
      4'd10: begin t = b0 + x; return {rd({8'h00, t + 8'd1}), rd({8'h00, t})}; end
      4'd11: begin
        t = b0 + 8'd1; base = {rd({8'h00, t}), rd({8'h00, b0})};
        s = base + {8'h00, y}; ref_cross = base[15:8] != s[15:8]; return s;
      end
      4'd12: return pc + 16'd2 + {{8{b0[7]}}, b0};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic run(input string tag, input logic [3:0] m, input logic pen,
                     input logic [15:0] pc, input logic [7:0] x, input logic [7:0] y,
                     input int exp_reads, input int exp_cyc);
    logic [15:0] e_ea, hold;
    logic cr;
    int cyc;
    e_ea = ref_ea(m, pc, x, y, cr);
    reads = 0;
    @(negedge clk);
    start = 1'b1; mode = m; pen_en = pen; pc_in = pc; idx_x = x; idx_y = y;
    @(negedge clk);
    start = 1'b0; mode = 4'hF; pc_in = 16'hDEAD; idx_x = 8'h77; idx_y = 8'h66;
    cyc = 1;
    while (!done && cyc < 500) begin @(negedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL %s R11 no done actual=0 expected=1", tag);
      return;
    end
    chk({tag, " ea"}, ea, e_ea);
    chk({tag, " R1 pc_out"}, pc_out, pc + {14'd0, ref_len(m)});
    chk({tag, " R1 op_len"}, {14'd0, op_len}, {14'd0, ref_len(m)});
    chk({tag, " R8 extra_cyc"}, {15'd0, extra_cyc}, {15'd0, pen & cr});
    chk({tag, " R10 reads"}, 16'(reads), 16'(exp_reads));
    if (exp_cyc > 0) chk({tag, " R2 cycles"}, 16'(cyc), 16'(exp_cyc));
    hold = ea;
    @(negedge clk);
    chk({tag, " R11 done pulse"}, {15'd0, done}, 16'd0);
    chk({tag, " R11 ea held"}, ea, hold);
  endtask

  task automatic t_fast();
    run("R2 implicit", 4'd0, 1'b1, 16'h1234, 8'h10, 8'h20, 0, 1);
    run("R2 accumulator", 4'd1, 1'b0, 16'hFFFF, 8'h00, 8'h00, 0, 1);
    run("R2 reserved", 4'd14, 1'b1, 16'h4000, 8'h01, 8'h01, 0, 1);
    run("R2 immediate", 4'd2, 1'b1, 16'hFFFF, 8'h00, 8'h00, 0, 1);
  endtask

  task automatic t_zp();
    ov_n = 0; poke(16'h0301, 8'hF0);
    run("R3 zp", 4'd3, 1'b1, 16'h0300, 8'h20, 8'h05, 1, -1);
    run("R3 zpx wrap", 4'd4, 1'b1, 16'h0300, 8'h20, 8'h05, 1, -1);
    run("R3 zpy", 4'd5, 1'b1, 16'h0300, 8'h20, 8'h05, 1, -1);
  endtask

  task automatic t_abs();
    ov_n = 0;
    poke(16'h2001, 8'h80); poke(16'h2002, 8'h12);
    run("R4 abs", 4'd6, 1'b1, 16'h2000, 8'h10, 8'h90, 2, -1);
    run("R4 abx same page", 4'd7, 1'b1, 16'h2000, 8'h10, 8'h90, 2, -1);
    run("R8 aby cross pen", 4'd8, 1'b1, 16'h2000, 8'h10, 8'h90, 2, -1);
    run("R8 aby cross nopen", 4'd8, 1'b0, 16'h2000, 8'h10, 8'h90, 2, -1);
    poke(16'hFFFF, 8'hF0); poke(16'h0000, 8'hFF);
    run("R4 abx wrap pc", 4'd7, 1'b1, 16'hFFFE, 8'h20, 8'h00, 2, -1);
  endtask

  task automatic t_ind();
    ov_n = 0;
    poke(16'h5001, 8'h34); poke(16'h5002, 8'h12);
    poke(16'h1234, 8'hCD); poke(16'h1235, 8'hAB);
    run("R5 ind", 4'd9, 1'b0, 16'h5000, 8'h00, 8'h00, 4, -1);
    ov_n = 0;
    poke(16'h5001, 8'hFF); poke(16'h5002, 8'h30);
    poke(16'h30FF, 8'h11); poke(16'h3000, 8'h22); poke(16'h3100, 8'h99);
    run("R5 ind page wrap", 4'd9, 1'b0, 16'h5000, 8'h00, 8'h00, 4, -1);
  endtask

  task automatic t_izx();
    ov_n = 0;
    poke(16'h6001, 8'hF0); poke(16'h00FF, 8'h78); poke(16'h0000, 8'h56);
    run("R6 izx wrap", 4'd10, 1'b1, 16'h6000, 8'h0F, 8'hFF, 3, -1);
    poke(16'h0010, 8'h9A); poke(16'h0011, 8'hBC);
    run("R6 izx plain", 4'd10, 1'b1, 16'h6000, 8'h20, 8'hFF, 3, -1);
  endtask

  task automatic t_izy();
    ov_n = 0;
    poke(16'h7001, 8'h40); poke(16'h0040, 8'hF0); poke(16'h0041, 8'h12);
    run("R7 izy cross pen", 4'd11, 1'b1, 16'h7000, 8'h00, 8'h20, 3, -1);
    run("R7 izy cross nopen", 4'd11, 1'b0, 16'h7000, 8'h00, 8'h20, 3, -1);
    run("R7 izy same page", 4'd11, 1'b1, 16'h7000, 8'h00, 8'h0F, 3, -1);
    ov_n = 0;
    poke(16'h7001, 8'hFF); poke(16'h00FF, 8'hFF); poke(16'h0000, 8'hFF);
    run("R7 izy ptr wrap", 4'd11, 1'b1, 16'h7000, 8'h00, 8'h01, 3, -1);
  endtask

  task automatic t_rel();
    ov_n = 0;
    poke(16'h8001, 8'h10);
    run("R9 rel fwd", 4'd12, 1'b1, 16'h8000, 8'h00, 8'h00, 1, -1);
    poke(16'h9001, 8'h80);
    run("R9 rel back", 4'd12, 1'b1, 16'h9000, 8'h00, 8'h00, 1, -1);
    poke(16'hFFFF, 8'h05);
    run("R9 rel pc wrap", 4'd12, 1'b1, 16'hFFFE, 8'h00, 8'h00, 1, -1);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R11 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = '0; pen_en = 1'b0; pc_in = '0;
    idx_x = '0; idx_y = '0; mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("reset R11 done", {15'd0, done}, 16'd0);
    chk("reset R10 mem_req", {15'd0, mem_req}, 16'd0);
    rst_n = 1'b1;
    for (int l = 0; l < 3; l++) begin
      lat = (l == 2) ? 3 : l;
      t_fast(); t_zp(); t_abs(); t_ind(); t_izx(); t_izy(); t_rel();
    end
    chk("R10 handshake violations", 16'(hs_err), 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule